// File: doc/BRIEF.md
# Conditional DMA Store Executor

This block carries out one DMA channel's store instructions in both forms: the plain store and the store that also notifies a peripheral. It takes a decoded instruction word and reads its two condition bits. It compares them with a request-type flag that it latches whenever a wait-for-peripheral instruction fires. Depending on the result, it either retires the instruction as a no-op or moves one burst from the shared data FIFO to the destination address over an AXI write channel.

The block waits before sending the write address until the FIFO holds every byte the burst needs. It consumes one FIFO entry per accepted data beat. It retires the instruction when the write response arrives. At that point it reports the next program counter. It may also step the destination address, pulse a peripheral acknowledge, or record a fault.

Top module: `dse_store_exec`

## Requirements
- R1: When the condition-enable bit `instr_word[0]` is 0, the store always executes, with `awlen` equal to `ctl_len`, whatever the request-type flag holds.
- R2: When `instr_word[0]` is 1 and the burst-select bit `instr_word[1]` differs from the request-type flag (1 = burst), the instruction is a no-op. `done` pulses, no AXI or FIFO activity occurs, and `da_o` keeps its value.
- R3: A store with `instr_word[1:0]=01` executed while the flag is single issues `awlen=0` (one beat) and ignores `ctl_len`.
- R4: An executed store sends `awlen+1` data beats, each popping one FIFO entry, with `wlast` on the final beat only. `awaddr` equals `da_o` at issue, and `awsize` equals `ctl_size`.
- R5: The request-type flag takes the value of `wfp_burst` only in a cycle where `wfp_fire` is 1. It holds otherwise.
- R6: `awvalid` does not rise until `fifo_level` is at least (awlen+1) << awsize bytes.
- R7: In the notify form (`instr_notify=1`), `ack` pulses together with `done`, only after an OKAY (`bresp=00`) write response, and `ack_periph` carries `instr_word[15:11]`. The plain form never raises `ack`.
- R8: With `ctl_inc` set, `da_o` grows by (awlen+1) << awsize when an executed store completes. With it clear, `da_o` is unchanged.
- R9: `pc_next`, valid while `done` is 1, is `pc_i` plus 1 for the plain form and plus 2 for the notify form, for both no-ops and executed stores.
- R10: A write response other than OKAY sets `fault`, which stays set until reset, and that store raises no `ack`.
- R11: `instr_ready` is 1 only when no store is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr_notify | input | 1 | 1 = notify-peripheral form (two bytes) |
| instr_word | input | 16 | Instruction; [0] condition enable, [1] burst select, [15:11] peripheral |
| pc_i | input | PC_W | Address of the instruction |
| instr_ready | output | 1 | Idle, can accept an instruction |
| done | output | 1 | Instruction retired pulse |
| pc_next | output | PC_W | Next program counter |
| wfp_fire | input | 1 | Wait-for-peripheral executes |
| wfp_burst | input | 1 | Request type from that instruction, 1 = burst |
| ctl_len | input | 4 | Programmed destination burst length minus one |
| ctl_size | input | 3 | log2 of destination beat bytes |
| ctl_inc | input | 1 | Destination increment enable |
| da_load | input | 1 | Load destination address |
| da_load_val | input | ADDR_W | Value to load |
| da_o | output | ADDR_W | Destination address register |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 4 | Burst length minus one |
| awsize | output | 3 | Beat size |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wlast | output | 1 | Last beat |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |
| bresp | input | 2 | Response code |
| fifo_level | input | LVL_W | Bytes held in the data FIFO |
| fifo_data | input | DATA_W | FIFO head entry |
| fifo_rd | output | 1 | Pop FIFO head |
| ack | output | 1 | Peripheral acknowledge pulse |
| ack_periph | output | 5 | Peripheral number for ack |
| fault | output | 1 | Sticky write-fault flag |

## Verification
If the latched request type is wrong, the next conditional store flips between executing and skipping. The port shows this in the cycle after the instruction is taken, as `done` with no address phase, or as an address phase where none should be. If the beat counter or latched length is corrupted, it shows at the AXI port within one burst: `wlast` falls on the wrong beat or the FIFO pop count differs from awlen+1. An address or fault register in the wrong state becomes visible at `da_o`, `awaddr` or `ack` as soon as the store that uses it retires.

// File: rtl/dse_pkg.sv
package dse_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_WAIT, ST_ADDR, ST_DATA, ST_RESP
   } dse_state_e;

   typedef struct packed {
      logic       cond_en;
      logic       burst_sel;
      logic       notify;
      logic [4:0] periph;
   } dse_instr_t;

   localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/dse_decode.sv
module dse_decode
   import dse_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic [15:0]      instr_word,
   input  logic             instr_notify,
   input  logic             req_burst,
   input  logic [LEN_W-1:0] ctl_len,
   output dse_instr_t       dec,
   output logic             run,
   output logic [LEN_W-1:0] eff_len,
   output logic [1:0]       ilen
);
   always_comb begin
      dec.cond_en   = instr_word[0];
      dec.burst_sel = instr_word[1];
      dec.notify    = instr_notify;
      dec.periph    = instr_notify ? instr_word[15:11] : 5'd0;
      run     = !dec.cond_en || (dec.burst_sel == req_burst);
      eff_len = (dec.cond_en && !dec.burst_sel) ? '0 : ctl_len;
      ilen    = instr_notify ? 2'd2 : 2'd1;
   end
endmodule

// File: rtl/dse_beats.sv
module dse_beats #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len_in,
   input  logic             step,
   output logic             last
);
   logic [LEN_W-1:0] cnt_q, len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
      end else if (load) begin
         cnt_q <= '0;
         len_q <= len_in;
      end else if (step && !last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == len_q);
endmodule

// File: rtl/dse_store_exec.sv
module dse_store_exec
   import dse_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int PC_W   = 32,
   parameter int LVL_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic              instr_notify,
   input  logic [15:0]       instr_word,
   input  logic [PC_W-1:0]   pc_i,
   output logic              instr_ready,
   output logic              done,
   output logic [PC_W-1:0]   pc_next,
   input  logic              wfp_fire,
   input  logic              wfp_burst,
   input  logic [3:0]        ctl_len,
   input  logic [2:0]        ctl_size,
   input  logic              ctl_inc,
   input  logic              da_load,
   input  logic [ADDR_W-1:0] da_load_val,
   output logic [ADDR_W-1:0] da_o,
   output logic              awvalid,
   input  logic              awready,
   output logic [ADDR_W-1:0] awaddr,
   output logic [3:0]        awlen,
   output logic [2:0]        awsize,
   output logic              wvalid,
   input  logic              wready,
   output logic [DATA_W-1:0] wdata,
   output logic              wlast,
   input  logic              bvalid,
   output logic              bready,
   input  logic [1:0]        bresp,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              fifo_rd,
   output logic              ack,
   output logic [4:0]        ack_periph,
   output logic              fault
);
   localparam int LEN_W  = 4;
   localparam int NEED_W = LEN_W + 8;

   generate
      if (DATA_W < 8 || DATA_W > 1024 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         initial $error("DATA_W must be a power of two from 8 to 1024");
      end
      if (LVL_W < NEED_W) begin : g_bad_lvl
         initial $error("LVL_W too small for the largest burst");
      end
      if (ADDR_W < NEED_W) begin : g_bad_addr
         initial $error("ADDR_W too small");
      end
   endgenerate

   dse_state_e       st_q;
   dse_instr_t       dec, ins_q;
   logic             run, req_burst_q, inc_q, accept, beat_last;
   logic [LEN_W-1:0] eff_len, len_q;
   logic [1:0]       ilen;
   logic [2:0]       size_q;
   logic [NEED_W-1:0] need;

   dse_decode #(.LEN_W(LEN_W)) u_dec (
      .instr_word  (instr_word),
      .instr_notify(instr_notify),
      .req_burst   (req_burst_q),
      .ctl_len     (ctl_len),
      .dec         (dec),
      .run         (run),
      .eff_len     (eff_len),
      .ilen        (ilen)
   );

   assign accept = (st_q == ST_IDLE) && instr_valid;

   dse_beats #(.LEN_W(LEN_W)) u_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .len_in(eff_len),
      .step  (fifo_rd),
      .last  (beat_last)
   );

   assign need = (NEED_W'(len_q) + NEED_W'(1)) << size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_burst_q <= 1'b0;
      else if (wfp_fire) req_burst_q <= wfp_burst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         ins_q      <= '0;
         len_q      <= '0;
         size_q     <= '0;
         inc_q      <= 1'b0;
         pc_next    <= '0;
         da_o       <= '0;
         done       <= 1'b0;
         ack        <= 1'b0;
         ack_periph <= '0;
         fault      <= 1'b0;
      end else begin
         done <= 1'b0;
         ack  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (da_load) da_o <= da_load_val;
               if (instr_valid) begin
                  ins_q   <= dec;
                  len_q   <= eff_len;
                  size_q  <= ctl_size;
                  inc_q   <= ctl_inc;
                  pc_next <= pc_i + PC_W'(ilen);
                  if (run) st_q <= ST_WAIT;
                  else     done <= 1'b1;
               end
            end
            ST_WAIT: if (fifo_level >= LVL_W'(need)) st_q <= ST_ADDR;
            ST_ADDR: if (awready) st_q <= ST_DATA;
            ST_DATA: if (wready && beat_last) st_q <= ST_RESP;
            ST_RESP: begin
               if (bvalid) begin
                  st_q <= ST_IDLE;
                  done <= 1'b1;
                  if (bresp == RESP_OKAY) begin
                     ack        <= ins_q.notify;
                     ack_periph <= ins_q.periph;
                  end else begin
                     fault <= 1'b1;
                  end
                  if (inc_q) da_o <= da_o + ADDR_W'(need);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign instr_ready = (st_q == ST_IDLE);
   assign awvalid     = (st_q == ST_ADDR);
   assign awaddr      = da_o;
   assign awlen       = len_q;
   assign awsize      = size_q;
   assign wvalid      = (st_q == ST_DATA);
   assign wdata       = fifo_data;
   assign wlast       = wvalid && beat_last;
   assign fifo_rd     = wvalid && wready;
   assign bready      = (st_q == ST_RESP);
endmodule

// File: rtl/dse_store_exec_chk.sv
module dse_store_exec_chk #(
   parameter int ADDR_W = 32,
   parameter int LVL_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_ready,
   input logic              awvalid,
   input logic              awready,
   input logic [ADDR_W-1:0] awaddr,
   input logic [3:0]        awlen,
   input logic [2:0]        awsize,
   input logic              wvalid,
   input logic              bvalid,
   input logic              bready,
   input logic [1:0]        bresp,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              ack,
   input logic              fault
);
   logic [LVL_W-1:0] burst_bytes;
   assign burst_bytes = (LVL_W'(awlen) + LVL_W'(1)) << awsize;

   a_r6_fifo_full: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> fifo_level >= burst_bytes);

   a_r4_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

   a_r7_ack_after_okay: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(bvalid && bready && bresp == 2'b00));

   a_r10_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(bvalid && bready && bresp != 2'b00));

   a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid || wvalid || bready) |-> !instr_ready);
endmodule

bind dse_store_exec dse_store_exec_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .awvalid(awvalid),
   .awready(awready), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
   .wvalid(wvalid), .bvalid(bvalid), .bready(bready), .bresp(bresp),
   .fifo_level(fifo_level), .ack(ack), .fault(fault)
);

// File: tb/dse_store_exec_test.sv
`timescale 1ns/1ps
module dse_store_exec_test;
   logic        clk = 0, rst_n = 0;
   logic        instr_valid = 0, instr_notify = 0;
   logic [15:0] instr_word = 0;
   logic [31:0] pc_i = 32'd100;
   logic        instr_ready, done;
   logic [31:0] pc_next;
   logic        wfp_fire = 0, wfp_burst = 0;
   logic [3:0]  ctl_len = 0;
   logic [2:0]  ctl_size = 2;
   logic        ctl_inc = 1;
   logic        da_load = 0;
   logic [31:0] da_load_val = 0, da_o;
   logic        awvalid, awready = 1;
   logic [31:0] awaddr;
   logic [3:0]  awlen;
   logic [2:0]  awsize;
   logic        wvalid, wready = 1, wlast;
   logic [31:0] wdata;
   logic        bvalid = 0, bready;
   logic [1:0]  bresp = 0;
   logic [11:0] fifo_level = 0;
   logic [31:0] fifo_data = 32'hA5A5_0000;
   logic        fifo_rd, ack, fault;
   logic [4:0]  ack_periph;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   dse_store_exec uut (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_flag(input bit burst);
      @(negedge clk); wfp_fire = 1; wfp_burst = burst;
      @(negedge clk); wfp_fire = 0; wfp_burst = ~burst;
   endtask

   // Runs one store and checks its port-level outcome.
   task automatic run_store(input string req, input bit notify, input bit x, input bit bs,
                            input logic [4:0] periph, input int stall, input logic [1:0] resp,
                            input bit exp_exec, input int exp_len, input bit exp_ack);
      int need, aw_cnt, beats, rd_cnt, last_bad, got_len, stall_aw, ack_cnt, busy_bad;
      bit seen_done;
      logic [31:0] da0, got_addr;
      need = (exp_len + 1) << ctl_size;
      da0 = da_o;
      aw_cnt = 0; beats = 0; rd_cnt = 0; last_bad = 0; got_len = -1; stall_aw = 0;
      ack_cnt = 0; busy_bad = 0; seen_done = 0; got_addr = 0;
      @(negedge clk);
      instr_valid = 1; instr_notify = notify;
      instr_word = {periph, 9'd0, bs, x};
      fifo_level = (stall > 0) ? 12'(need - 1) : 12'(need);
      @(negedge clk);
      instr_valid = 0;
      for (int i = 0; i < 80; i++) begin
         if (done) begin seen_done = 1; break; end
         if (ack) ack_cnt++;
         if (i >= stall) fifo_level = 12'(need);
         else if (awvalid) stall_aw++;
         if (awvalid) begin
            aw_cnt++; got_len = awlen; got_addr = awaddr;
            if (instr_ready) busy_bad++;
         end
         if (fifo_rd) rd_cnt++;
         if (wvalid && wready) begin
            beats++;
            if (wlast != (beats == got_len + 1)) last_bad++;
         end
         if (bready) begin bvalid = 1; bresp = resp; end
         @(negedge clk);
      end
      check(seen_done, req, "done pulse", seen_done, 1);
      check(pc_next == pc_i + (notify ? 2 : 1), "R9", "pc_next", pc_next, pc_i + (notify ? 2 : 1));
      if (ack) ack_cnt++;
      if (exp_exec) begin
         check(aw_cnt == 1, req, "address phases", aw_cnt, 1);
         check(got_len == exp_len, req, "awlen", got_len, exp_len);
         check(got_addr == da0, "R4", "awaddr", got_addr, da0);
         check(beats == exp_len + 1 && rd_cnt == beats && last_bad == 0, "R4",
               "beats/pops/wlast", beats * 100 + rd_cnt, (exp_len + 1) * 101);
         check(stall_aw == 0, "R6", "awvalid while FIFO short", stall_aw, 0);
         check(busy_bad == 0, "R11", "instr_ready while busy", busy_bad, 0);
         check(da_o == (ctl_inc ? da0 + need : da0), "R8", "da_o",
               da_o, ctl_inc ? da0 + need : da0);
      end else begin
         check(aw_cnt == 0 && rd_cnt == 0, "R2", "bus activity on no-op", aw_cnt + rd_cnt, 0);
         check(da_o == da0, "R2", "da_o after no-op", da_o, da0);
      end
      check(ack_cnt == (exp_ack ? 1 : 0), "R7", "ack count", ack_cnt, exp_ack ? 1 : 0);
      if (exp_ack) check(ack_periph == periph, "R7", "ack_periph", ack_periph, periph);
      bvalid = 0; bresp = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(instr_ready && !awvalid && !wvalid && !bready && !ack && !fault && !done,
            "R11", "reset outputs", 0, 0);
      check(da_o == 0, "R8", "reset da_o", da_o, 0);
      rst_n = 1;
      @(negedge clk); da_load = 1; da_load_val = 32'h1000;
      @(negedge clk); da_load = 0;
      check(da_o == 32'h1000, "R8", "da load", da_o, 32'h1000);
   end

   task automatic t_plain();     // R1
      set_flag(0); ctl_len = 3; ctl_inc = 1;
      run_store("R1", 0, 0, 0, 0, 0, 2'b00, 1, 3, 0);
      set_flag(1);
      run_store("R1", 0, 0, 0, 0, 0, 2'b00, 1, 3, 0);
   endtask

   task automatic t_single();    // R3
      set_flag(0); ctl_len = 7;
      run_store("R3", 0, 1, 0, 0, 0, 2'b00, 1, 0, 0);
   endtask

   task automatic t_skip();      // R2
      set_flag(1);
      run_store("R2", 0, 1, 0, 0, 0, 2'b00, 0, 0, 0);
      set_flag(0);
      run_store("R2", 1, 1, 1, 5'd3, 0, 2'b00, 0, 0, 0);
   endtask

   task automatic t_notify();    // R7
      set_flag(1); ctl_len = 2; ctl_size = 1;
      run_store("R7", 1, 1, 1, 5'd9, 0, 2'b00, 1, 2, 1);
      ctl_size = 2;
   endtask

   task automatic t_noinc();     // R8
      ctl_inc = 0; ctl_len = 1;
      run_store("R8", 0, 0, 0, 0, 0, 2'b00, 1, 1, 0);
      ctl_inc = 1;
   endtask

   task automatic t_stall();     // R6
      ctl_len = 4;
      run_store("R6", 0, 0, 0, 0, 6, 2'b00, 1, 4, 0);
   endtask

   task automatic t_flag_hold(); // R5: wfp_burst moves without wfp_fire
      set_flag(0); ctl_len = 5;
      @(negedge clk); wfp_burst = 1;
      run_store("R5", 0, 1, 0, 0, 0, 2'b00, 1, 0, 0);
      run_store("R5", 0, 1, 1, 0, 0, 2'b00, 0, 0, 0);
   endtask

   task automatic t_fault();     // R10
      set_flag(1); ctl_len = 1;
      run_store("R10", 1, 1, 1, 5'd17, 0, 2'b10, 1, 1, 0);
      check(fault == 1, "R10", "fault set", fault, 1);
      run_store("R10", 0, 0, 0, 0, 0, 2'b00, 1, 1, 0);
      check(fault == 1, "R10", "fault sticky", fault, 1);
   endtask

   initial begin
      repeat (6) @(negedge clk);
      t_plain();
      t_single();
      t_skip();
      t_notify();
      t_noinc();
      t_stall();
      t_flag_hold();
      t_fault();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule